// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns single host read and write requests into timed cycles on an external asynchronous static memory. It drives an active-low chip select, output enable and write enable, four active-low byte-lane strobes, a held address bus and a write-data bus with its own output-enable. The host side takes a request through a valid/ready handshake, with 32-bit data and byte enables. Completion comes back as a one-cycle response pulse that carries read data and an error flag.

The cycle shape comes from per-bank configuration inputs: a chip-select-to-write-enable delay, separate read and write wait counts, a shared extended-wait count with its enable, a byte-lane strobe mode and a write-protect bit. The controller samples these when it accepts a request, so a change made during a transfer acts only on the next one. Every memory cycle is followed by one idle cycle in which all strobes are high and the data bus is released.

Top module: `static_mem_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select, output enable, write enable and all byte-lane strobes are high (1), the write-data enable is 0, `reqReady` is 1 and `rspValid` is 0.
- R2: A read accepted at a clock edge holds chip select and output enable low for exactly W+1 cycles, starting in the next cycle, with W the selected wait count. `memDin` is captured in the last of those cycles. `rspValid` is 1 with that data, and `rspErr` is 0, in the single cycle after chip select rises.
- R3: A write holds chip select low for D+W+2 cycles, with D the write-enable delay. Write enable is low from cycle index D (counting from 0) for W+1 cycles, and it is high again in the last chip-select cycle. `rspValid` is 1, with `rspErr` 0, in the cycle after chip select rises.
- R4: During a write, `memDoe` is 1 and `memDout` holds the request data for every chip-select-low cycle, and `memDoe` is 0 at all other times. `memAddr` holds the request address for the whole chip-select-low window.
- R5: With `cfgLaneMode` = 0, every byte-lane strobe stays high during reads. During writes, strobe i goes low exactly in the cycles where write enable is low, and only if `reqBe[i]` = 1.
- R6: With `cfgLaneMode` = 1, strobe i is low for the whole chip-select-low window of both reads and writes if `reqBe[i]` = 1, and it stays high otherwise.
- R7: With `cfgExtEn` = 1, W is `cfgExtWait` for both reads and writes, and the read and write wait counts are ignored.
- R8: A write accepted while `cfgWrProt` = 1 drives no memory strobe and no data. It gives `rspValid` = 1 with `rspErr` = 1 in the next cycle, and `reqReady` stays 1. Reads are not affected by the protect bit.
- R9: Configuration is sampled at request acceptance. Changing any configuration input during a transfer does not change that transfer's cycles.
- R10: `reqReady` is 1 only when the controller is idle with every strobe high. It is 0 in the cycle in which chip select rises, so at least one idle cycle separates two memory cycles.
- R11: Output enable and write enable are never low together, and write enable is low only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables, bit i selects byte lane i |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Completion was a rejected protected write |
| rspRdata | output | DATA_W | Read data captured from the memory |
| cfgWenDelay | input | CNT_W | Cycles from chip select low to write enable low |
| cfgRdWait | input | CNT_W | Read wait count |
| cfgWrWait | input | CNT_W | Write wait count |
| cfgExtWait | input | EXT_W | Shared extended wait count |
| cfgExtEn | input | 1 | Use the extended wait count |
| cfgLaneMode | input | 1 | Byte-lane strobe mode |
| cfgWrProt | input | 1 | Reject writes |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBlsN | output | DATA_W/8 | Byte-lane strobes, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | DATA_W | Write data to the memory |
| memDoe | output | 1 | Drive enable for memDout |
| memDin | input | DATA_W | Read data from the memory |

## Verification
All memory strobes begin in the cycle right after the accepting edge. A protected write's error response appears one cycle after acceptance. A normal response appears one cycle after the last chip-select-low cycle, and that cycle lands D+W+3 cycles after acceptance for a write and W+2 cycles after it for a read. The reference model sees acceptance at the same rising edge as the design and pushes one expected record per future cycle into a queue. On each falling edge, halfway between rising edges, it pops one record and compares every strobe, bus and response output against it. An empty queue stands for the idle state. Configuration is changed in the middle of a transfer to show that the records pushed at acceptance still match.

// File: rtl/static_mem_pkg.sv
package static_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } seq_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch request fields and lane mode
    logic csAct;     // chip select window
    logic oeAct;     // output enable window (reads)
    logic weAct;     // write enable pulse
    logic wrCycle;   // current access is a write
    logic sampleRd;  // last read cycle, capture memDin
    logic done;      // last access cycle, raise response next cycle
    logic errSet;    // protected write rejected
  } seq_strobe_t;

endpackage

// File: rtl/static_mem_seq.sv
module static_mem_seq
  import static_mem_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int EXT_W = 10,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] cfgWenDelay,
  input  logic [CNT_W-1:0] cfgRdWait,
  input  logic [CNT_W-1:0] cfgWrWait,
  input  logic [EXT_W-1:0] cfgExtWait,
  input  logic             cfgExtEn,
  input  logic             cfgWrProt,
  output logic             reqReady,
  output seq_strobe_t      strb
);

  seq_state_t state;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] lastIdx;
  logic [LEN_W-1:0] weLo;
  logic [LEN_W-1:0] weHi;
  logic             isWr;

  logic [LEN_W-1:0] waitSel;
  logic [LEN_W-1:0] delayExt;
  logic             accept;
  logic             protHit;
  logic             lastCycle;

  assign accept    = reqValid && (state == ST_IDLE);
  assign protHit   = accept && reqWrite && cfgWrProt;
  assign delayExt  = LEN_W'(cfgWenDelay);
  assign lastCycle = (state == ST_ACCESS) && (idx == lastIdx);

  // wait source selection: shared extended count overrides both
  always_comb begin
    if (cfgExtEn)      waitSel = LEN_W'(cfgExtWait);
    else if (reqWrite) waitSel = LEN_W'(cfgWrWait);
    else               waitSel = LEN_W'(cfgRdWait);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      weLo    <= '0;
      weHi    <= '0;
      isWr    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && !protHit) begin
            state <= ST_ACCESS;
            idx   <= '0;
            isWr  <= reqWrite;
            weLo  <= delayExt;
            weHi  <= delayExt + waitSel;
            if (reqWrite) lastIdx <= delayExt + waitSel + LEN_W'(1);
            else          lastIdx <= waitSel;
          end
        end
        ST_ACCESS: begin
          if (idx == lastIdx) state <= ST_GAP;
          else                idx   <= idx + LEN_W'(1);
        end
        ST_GAP:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strb          = '0;
    strb.capture  = accept && !protHit;
    strb.errSet   = protHit;
    strb.csAct    = (state == ST_ACCESS);
    strb.wrCycle  = (state == ST_ACCESS) && isWr;
    strb.oeAct    = (state == ST_ACCESS) && !isWr;
    strb.weAct    = (state == ST_ACCESS) && isWr && (idx >= weLo) && (idx <= weHi);
    strb.sampleRd = lastCycle && !isWr;
    strb.done     = lastCycle;
  end

endmodule

// File: rtl/static_mem_dp.sv
module static_mem_dp
  import static_mem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic              cfgLaneMode,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memBlsN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;
  logic              laneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
      laneQ <= 1'b0;
    end else if (strb.capture) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      beQ   <= reqBe;
      laneQ <= cfgLaneMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strb.done || strb.errSet;
      rspErr   <= strb.errSet;
      if (strb.sampleRd) rspRdata <= memDin;
    end
  end

  assign memCsN  = ~strb.csAct;
  assign memOeN  = ~strb.oeAct;
  assign memWeN  = ~strb.weAct;
  assign memDoe  = strb.wrCycle;
  assign memDout = dataQ;
  assign memAddr = addrQ;

  // per-lane strobe: write-strobe style or byte-select style
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneLow;
    always_comb begin
      if (strb.wrCycle) laneLow = beQ[i] && (laneQ ? strb.csAct : strb.weAct);
      else              laneLow = beQ[i] && laneQ && strb.oeAct;
    end
    assign memBlsN[i] = ~laneLow;
  end

endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl
  import static_mem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int EXT_W  = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  output logic                  rspValid,
  output logic                  rspErr,
  output logic [DATA_W-1:0]     rspRdata,
  input  logic [CNT_W-1:0]      cfgWenDelay,
  input  logic [CNT_W-1:0]      cfgRdWait,
  input  logic [CNT_W-1:0]      cfgWrWait,
  input  logic [EXT_W-1:0]      cfgExtWait,
  input  logic                  cfgExtEn,
  input  logic                  cfgLaneMode,
  input  logic                  cfgWrProt,
  output logic                  memCsN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic [DATA_W/8-1:0]   memBlsN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDout,
  output logic                  memDoe,
  input  logic [DATA_W-1:0]     memDin
);

  localparam int LANES = DATA_W / 8;
  localparam int WMAX  = (EXT_W > CNT_W) ? EXT_W : CNT_W;
  localparam int LEN_W = WMAX + 2;

  seq_strobe_t strb;

  static_mem_seq #(
    .CNT_W(CNT_W), .EXT_W(EXT_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .cfgWenDelay(cfgWenDelay),
    .cfgRdWait  (cfgRdWait),
    .cfgWrWait  (cfgWrWait),
    .cfgExtWait (cfgExtWait),
    .cfgExtEn   (cfgExtEn),
    .cfgWrProt  (cfgWrProt),
    .reqReady   (reqReady),
    .strb       (strb)
  );

  static_mem_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqBe      (reqBe),
    .cfgLaneMode(cfgLaneMode),
    .memDin     (memDin),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memBlsN    (memBlsN),
    .memAddr    (memAddr),
    .memDout    (memDout),
    .memDoe     (memDoe),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .rspRdata   (rspRdata)
  );

endmodule

// File: rtl/static_mem_ctrl_chk.sv
module static_mem_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic reqWrite,
  input logic cfgWrProt,
  input logic rspValid,
  input logic rspErr,
  input logic memCsN,
  input logic memOeN,
  input logic memWeN,
  input logic memDoe
);

  a_r11_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  a_r11_we_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCsN);

  a_r3_we_rises_before_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memCsN);

  a_r4_doe_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> (!memCsN && memOeN));

  a_r2_oe_inside_cs: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCsN && !memDoe));

  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCsN && memOeN && memWeN && !memDoe));

  a_r10_gap_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCsN) |-> !reqReady);

  a_r8_prot_write_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && cfgWrProt) |=> (memCsN && rspValid && rspErr));

endmodule

bind static_mem_ctrl static_mem_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .cfgWrProt(cfgWrProt),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .memCsN   (memCsN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memDoe   (memDoe)
);

// File: tb/sim_static_mem_ctrl.sv
`timescale 1ns/1ps
module sim_static_mem_ctrl;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int CW = 5;
  localparam int EW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [3:0] reqBe = '0;
  logic [CW-1:0] cfgWenDelay = '0;
  logic [CW-1:0] cfgRdWait = '0;
  logic [CW-1:0] cfgWrWait = '0;
  logic [EW-1:0] cfgExtWait = '0;
  logic cfgExtEn = 1'b0;
  logic cfgLaneMode = 1'b0;
  logic cfgWrProt = 1'b0;

  logic reqReady, rspValid, rspErr, memCsN, memOeN, memWeN, memDoe;
  logic [DW-1:0] rspRdata, memDout, memDin;
  logic [3:0] memBlsN;
  logic [AW-1:0] memAddr;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [DW-1:0] memVal(input logic [AW-1:0] a);
    return 32'h5A00_0000 ^ {8'h00, a} ^ {a[7:0], 24'h0};
  endfunction

  assign memDin = !memOeN ? memVal(memAddr) : 32'hDEAD_BEEF;

  static_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .EXT_W(EW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .cfgWenDelay(cfgWenDelay), .cfgRdWait(cfgRdWait), .cfgWrWait(cfgWrWait),
    .cfgExtWait(cfgExtWait), .cfgExtEn(cfgExtEn), .cfgLaneMode(cfgLaneMode),
    .cfgWrProt(cfgWrProt), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memBlsN(memBlsN), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memDin(memDin));

  typedef struct {
    bit cs, oe, we, doe, rv, err, ready, rdChk;
    bit [3:0] bls;
    logic [DW-1:0] data;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit curReady = 1'b1;
  bit modelOn = 1'b0;

  function automatic exp_t idleRec();
    exp_t r;
    r.cs = 1; r.oe = 1; r.we = 1; r.doe = 0; r.rv = 0; r.err = 0;
    r.ready = 1; r.rdChk = 0; r.bls = 4'hF; r.data = '0; r.addr = '0;
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // reference model: pushes one expected record per future cycle at acceptance
  always @(posedge clk) begin
    if (modelOn && reqValid && curReady) begin
      int w;
      exp_t r;
      w = cfgExtEn ? int'(cfgExtWait) : (reqWrite ? int'(cfgWrWait) : int'(cfgRdWait));
      if (reqWrite && cfgWrProt) begin
        r = idleRec(); r.rv = 1; r.err = 1;
        q.push_back(r);
      end else if (!reqWrite) begin
        for (int k = 0; k <= w; k++) begin
          r = idleRec(); r.cs = 0; r.oe = 0; r.ready = 0; r.addr = reqAddr;
          r.bls = cfgLaneMode ? ~reqBe : 4'hF;
          q.push_back(r);
        end
        r = idleRec(); r.rv = 1; r.ready = 0; r.rdChk = 1; r.data = memVal(reqAddr);
        q.push_back(r);
      end else begin
        int d;
        d = int'(cfgWenDelay);
        for (int k = 0; k < d + w + 2; k++) begin
          bit weLow;
          weLow = (k >= d) && (k <= d + w);
          r = idleRec(); r.cs = 0; r.ready = 0; r.doe = 1; r.addr = reqAddr;
          r.data = reqWdata; r.we = !weLow;
          r.bls = cfgLaneMode ? ~reqBe : (weLow ? ~reqBe : 4'hF);
          q.push_back(r);
        end
        r = idleRec(); r.rv = 1; r.ready = 0;
        q.push_back(r);
      end
    end
  end

  // compare every cycle, halfway between rising edges
  always @(negedge clk) begin
    exp_t e;
    cycles++;
    if (modelOn) begin
      e = (q.size() != 0) ? q.pop_front() : idleRec();
      curReady = e.ready;
      chk("R2/R3", "memCsN", DW'(memCsN), DW'(e.cs));
      chk("R2/R11", "memOeN", DW'(memOeN), DW'(e.oe));
      chk("R3/R11", "memWeN", DW'(memWeN), DW'(e.we));
      chk("R5/R6", "memBlsN", DW'(memBlsN), DW'(e.bls));
      chk("R4", "memDoe", DW'(memDoe), DW'(e.doe));
      chk("R10", "reqReady", DW'(reqReady), DW'(e.ready));
      chk("R2/R8", "rspValid", DW'(rspValid), DW'(e.rv));
      if (e.rv) chk("R8", "rspErr", DW'(rspErr), DW'(e.err));
      if (e.rdChk) chk("R2", "rspRdata", rspRdata, e.data);
      if (e.doe) chk("R4", "memDout", memDout, e.data);
      if (!e.cs) chk("R4", "memAddr", DW'(memAddr), DW'(e.addr));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] be);
    @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; reqValid = 1'b1;
    do @(posedge clk); while (!curReady);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "csN in reset", DW'(memCsN), 1);
    chk("R1", "weN/oeN in reset", DW'({memWeN, memOeN}), 3);
    chk("R1", "blsN in reset", DW'(memBlsN), 32'hF);
    chk("R1", "doe/rsp in reset", DW'({memDoe, rspValid}), 0);
    chk("R1", "ready in reset", DW'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    modelOn = 1'b1;

    // R2, R5: plain read, strobe mode clear
    cfgRdWait = 5'd2;
    issue(1'b0, 24'h00_1234, '0, 4'hF); drain();
    // R3, R4, R5: write with delay
    cfgWenDelay = 5'd1; cfgWrWait = 5'd2;
    issue(1'b1, 24'h00_0040, 32'hCAFE_0001, 4'h5); drain();
    // R6: read and write with byte-select mode
    cfgLaneMode = 1'b1; cfgRdWait = 5'd0;
    issue(1'b0, 24'h12_0008, '0, 4'h3); drain();
    cfgWenDelay = 5'd0; cfgWrWait = 5'd0;
    issue(1'b1, 24'h12_000C, 32'h1122_3344, 4'hC); drain();
    // R7: extended wait overrides both counts
    cfgLaneMode = 1'b0; cfgExtEn = 1'b1; cfgExtWait = 10'd5; cfgRdWait = 5'd1;
    issue(1'b0, 24'h0F_F000, '0, 4'hF); drain();
    cfgExtWait = 10'd3; cfgWrWait = 5'd0; cfgWenDelay = 5'd2;
    issue(1'b1, 24'h0F_F004, 32'h8000_0007, 4'h9); drain();
    cfgExtEn = 1'b0;
    // R8: protected write rejected, read still served
    cfgWrProt = 1'b1;
    issue(1'b1, 24'h00_0100, 32'hFFFF_FFFF, 4'hF); drain();
    issue(1'b0, 24'h00_0104, '0, 4'hF); drain();
    cfgWrProt = 1'b0;
    // R9: configuration changed mid-transfer has no effect on it
    cfgRdWait = 5'd3; cfgLaneMode = 1'b1;
    issue(1'b0, 24'h00_0200, '0, 4'h6);
    cfgRdWait = 5'd0; cfgLaneMode = 1'b0; cfgExtEn = 1'b1; cfgExtWait = 10'd9;
    drain();
    cfgExtEn = 1'b0;
    cfgWenDelay = 5'd3; cfgWrWait = 5'd1;
    issue(1'b1, 24'h00_0300, 32'h0BAD_F00D, 4'hF);
    cfgWenDelay = 5'd0; cfgWrProt = 1'b1;
    drain();
    cfgWrProt = 1'b0;
    // R10: back-to-back requests, gap cycle between them
    cfgRdWait = 5'd1; cfgWrWait = 5'd1; cfgWenDelay = 5'd1;
    issue(1'b0, 24'h00_0400, '0, 4'hF);
    issue(1'b1, 24'h00_0404, 32'h1357_9BDF, 4'h2);
    issue(1'b0, 24'h00_0408, '0, 4'hF);
    drain();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule